// File: doc/BRIEF.md
# Masked Program-Counter Breakpoint Trigger

This block watches the program counter of a processor core and requests a debug breakpoint when the counter hits a programmed address. The compare is masked bit by bit. Each address bit is either required to equal the counter bit or is left out of the compare, so one setting can cover an aligned window of addresses. Debug software sets the block up through a write-only register port. The port carries a register index and a 32-bit data word.

The trigger can work at one level or at two levels. At one level, every qualifying match raises the request. At two levels, the first match only arms the unit. A later match while armed raises the request and disarms the unit again. This lets a breakpoint fire only on the second pass through an address. A trigger-definition register holds one enable for the first level in its lower half and one enable for the second level in its upper half.

Top module: `pc_brk_trigger`

## Requirements
- R1: After reset, `brk_req` is 0 and the address, mask and trigger-definition registers all read as zero in effect. With no register written, no program counter value ever raises `brk_req`. Once only the first-level enable is set, PC 0 matches and PC 1 does not.
- R2: A PC matches when every bit whose mask bit is 0 equals the corresponding address bit. Mask bits that are 1 are left out of the compare. The address register is written at index 0x08 and the mask register at index 0x09. A written value is used from the cycle after the write.
- R3: The trigger-definition register is written at index 0x07. Bit 0 is the first-level enable and bit 16 is the second-level enable, and all other bits have no effect. While bit 0 is 0, `brk_req` never rises, whatever bit 16 holds.
- R4: With bit 0 set and bit 16 clear (one level), a cycle with `pc_valid` high and a matching PC makes `brk_req` 1 in the next cycle. Each such cycle gives one cycle of request.
- R5: With both bits set (two levels), the first qualifying match arms the unit and leaves `brk_req` at 0. The next qualifying match while armed makes `brk_req` 1 in the next cycle and disarms the unit. The match after that only arms again.
- R6: A cycle with `pc_valid` low never arms the unit and never raises `brk_req`.
- R7: A write to the trigger-definition register disarms the unit. In the cycle of that write, a match neither arms nor fires.
- R8: A write to any index other than 0x07, 0x08 or 0x09 changes no register and has no effect on later matching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | 5 | Index of the register to write |
| reg_wr_data | input | 32 | Register write data |
| pc_valid | input | 1 | High when `pc` holds a counter value to compare |
| pc | input | 32 | Program counter of the executing instruction |
| brk_req | output | 1 | Breakpoint request, high for one cycle per firing |

## Verification
The assertions assume that `reg_wr_idx`, `reg_wr_data`, `pc_valid` and `pc` are stable around the rising edge. They also assume that `pc` carries meaning only while `pc_valid` is high. No assumption is made about how writes and compares overlap. The stimulus drives every input half a period away from the active edge. It deliberately puts register writes in the same cycle as matching valid PCs, including writes to unused indices. To reach matches often, the random PC is built from the current address with random flips confined to the masked bits.

// File: rtl/brk_pkg.sv
package brk_pkg;

   // offset of the enable bit inside each half of the trigger-definition word
   localparam int unsigned LVL_EN_OFS = 0;

   typedef enum logic [1:0] {
      TRIG_OFF    = 2'd0,
      TRIG_SINGLE = 2'd1,
      TRIG_DOUBLE = 2'd2
   } trig_mode_e;

   function automatic trig_mode_e decode_mode(input logic l1_en, input logic l2_en);
      trig_mode_e m;
      if (!l1_en)     m = TRIG_OFF;
      else if (l2_en) m = TRIG_DOUBLE;
      else            m = TRIG_SINGLE;
      return m;
   endfunction

endpackage

// File: rtl/brk_regfile.sv
module brk_regfile #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned IDX_W    = 5,
   parameter int unsigned ADDR_IDX = 8,
   parameter int unsigned MASK_IDX = 9,
   parameter int unsigned TRIG_IDX = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] bp_addr,
   output logic [DATA_W-1:0] bp_mask,
   output logic              l1_en,
   output logic              l2_en,
   output logic              trig_wr
);
   import brk_pkg::*;

   localparam int unsigned HALF   = DATA_W / 2;
   localparam int unsigned L1_BIT = LVL_EN_OFS;
   localparam int unsigned L2_BIT = HALF + LVL_EN_OFS;

   localparam logic [IDX_W-1:0] A_SEL = IDX_W'(ADDR_IDX);
   localparam logic [IDX_W-1:0] M_SEL = IDX_W'(MASK_IDX);
   localparam logic [IDX_W-1:0] T_SEL = IDX_W'(TRIG_IDX);

   logic addr_wr, mask_wr;

   assign addr_wr = wr_en && (wr_idx == A_SEL);
   assign mask_wr = wr_en && (wr_idx == M_SEL);
   assign trig_wr = wr_en && (wr_idx == T_SEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bp_addr <= '0;
      end else if (addr_wr) begin
         bp_addr <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bp_mask <= '0;
      end else if (mask_wr) begin
         bp_mask <= wr_data;
      end
   end

   // only the two enable bits of the trigger word carry meaning
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l1_en <= 1'b0;
         l2_en <= 1'b0;
      end else if (trig_wr) begin
         l1_en <= wr_data[L1_BIT];
         l2_en <= wr_data[L2_BIT];
      end
   end

   // R8
   keep_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == A_SEL) |=> $stable(bp_addr));

   // R8
   keep_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == M_SEL) |=> $stable(bp_mask));

   // R3
   keep_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == T_SEL) |=> ($stable(l1_en) && $stable(l2_en)));

endmodule

// File: rtl/brk_pc_match.sv
module brk_pc_match #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned SLICE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] pc,
   input  logic [DATA_W-1:0] bp_addr,
   input  logic [DATA_W-1:0] bp_mask,
   output logic              hit
);
   localparam int unsigned NSLICE = DATA_W / SLICE_W;

   generate
      if (SLICE_W == 0 || (DATA_W % SLICE_W) != 0) begin : g_bad_slice
         $error("brk_pc_match: SLICE_W must divide DATA_W");
      end
   endgenerate

   logic [NSLICE-1:0] slice_ok;

   generate
      if (NSLICE == 1) begin : g_flat
         assign slice_ok[0] = ((pc ^ bp_addr) & ~bp_mask) == '0;
      end else begin : g_sliced
         for (genvar s = 0; s < NSLICE; s++) begin : g_s
            logic [SLICE_W-1:0] diff;
            assign diff        = (pc[s*SLICE_W +: SLICE_W] ^ bp_addr[s*SLICE_W +: SLICE_W])
                                 & ~bp_mask[s*SLICE_W +: SLICE_W];
            assign slice_ok[s] = (diff == '0);
         end
      end
   endgenerate

   assign hit = &slice_ok;

   // R2
   exact_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc == bp_addr) |-> hit);

   // R2
   full_mask_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&bp_mask) |-> hit);

endmodule

// File: rtl/brk_sequencer.sv
module brk_sequencer (
   input  logic clk,
   input  logic rst_n,
   input  logic l1_en,
   input  logic l2_en,
   input  logic trig_wr,
   input  logic pc_valid,
   input  logic hit,
   output logic brk_req,
   output logic armed
);
   import brk_pkg::*;

   trig_mode_e mode;
   logic       take;

   assign mode = decode_mode(l1_en, l2_en);
   assign take = pc_valid && hit && !trig_wr && (mode != TRIG_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         brk_req <= 1'b0;
         armed   <= 1'b0;
      end else begin
         brk_req <= 1'b0;
         if (trig_wr) begin
            armed <= 1'b0;
         end else if (take) begin
            unique case (mode)
               TRIG_SINGLE: brk_req <= 1'b1;
               TRIG_DOUBLE: begin
                  if (armed) begin
                     brk_req <= 1'b1;
                     armed   <= 1'b0;
                  end else begin
                     armed   <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R6
   no_idle_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pc_valid |=> !brk_req);

   // R4
   fire_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req |-> ($past(pc_valid) && $past(hit)));

   // R3
   no_l1_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !l1_en |=> !brk_req);

   // R7
   wr_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_wr |=> (!armed && !brk_req));

   // R5
   fire_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && pc_valid && hit && !trig_wr) |=> (brk_req && !armed));

   // R5
   arm_needs_l2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> ($past(l2_en) && $past(pc_valid) && !brk_req));

endmodule

// File: rtl/pc_brk_trigger.sv
module pc_brk_trigger #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned IDX_W    = 5,
   parameter int unsigned ADDR_IDX = 8,
   parameter int unsigned MASK_IDX = 9,
   parameter int unsigned TRIG_IDX = 7,
   parameter int unsigned SLICE_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [IDX_W-1:0]  reg_wr_idx,
   input  logic [DATA_W-1:0] reg_wr_data,
   input  logic              pc_valid,
   input  logic [DATA_W-1:0] pc,
   output logic              brk_req
);
   localparam int unsigned IDX_SPAN = 1 << IDX_W;

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("pc_brk_trigger: DATA_W must be even and at least 4");
      end
      if (ADDR_IDX >= IDX_SPAN || MASK_IDX >= IDX_SPAN || TRIG_IDX >= IDX_SPAN) begin : g_bad_idx
         $error("pc_brk_trigger: register index does not fit IDX_W");
      end
      if (ADDR_IDX == MASK_IDX || ADDR_IDX == TRIG_IDX || MASK_IDX == TRIG_IDX) begin : g_dup_idx
         $error("pc_brk_trigger: register indices must differ");
      end
   endgenerate

   logic [DATA_W-1:0] bp_addr, bp_mask;
   logic              l1_en, l2_en, trig_wr, hit, armed;

   brk_regfile #(
      .DATA_W  (DATA_W),
      .IDX_W   (IDX_W),
      .ADDR_IDX(ADDR_IDX),
      .MASK_IDX(MASK_IDX),
      .TRIG_IDX(TRIG_IDX)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .wr_idx  (reg_wr_idx),
      .wr_data (reg_wr_data),
      .bp_addr (bp_addr),
      .bp_mask (bp_mask),
      .l1_en   (l1_en),
      .l2_en   (l2_en),
      .trig_wr (trig_wr)
   );

   brk_pc_match #(
      .DATA_W (DATA_W),
      .SLICE_W(SLICE_W)
   ) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .pc      (pc),
      .bp_addr (bp_addr),
      .bp_mask (bp_mask),
      .hit     (hit)
   );

   brk_sequencer u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .l1_en    (l1_en),
      .l2_en    (l2_en),
      .trig_wr  (trig_wr),
      .pc_valid (pc_valid),
      .hit      (hit),
      .brk_req  (brk_req),
      .armed    (armed)
   );

   // R1
   armed_only_two_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (l1_en && l2_en));

endmodule

// File: tb/sim_pc_brk_trigger.sv
`timescale 1ns/1ps
module sim_pc_brk_trigger;

   localparam int CLK_NS = 4;
   localparam logic [4:0] IX_ADDR = 5'h08;
   localparam logic [4:0] IX_MASK = 5'h09;
   localparam logic [4:0] IX_TRIG = 5'h07;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [4:0]  reg_wr_idx = '0;
   logic [31:0] reg_wr_data = '0;
   logic        pc_valid = 1'b0;
   logic [31:0] pc = '0;
   logic        brk_req;

   int errors = 0;
   int checks = 0;

   // bench-side expected state
   logic [31:0] m_addr = '0, m_mask = '0;
   logic        m_l1 = 1'b0, m_l2 = 1'b0, m_armed = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   pc_brk_trigger u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx),
      .reg_wr_data(reg_wr_data), .pc_valid(pc_valid), .pc(pc), .brk_req(brk_req)
   );

   function automatic logic pc_hits(input logic [31:0] p, input logic [31:0] a, input logic [31:0] m);
      for (int b = 0; b < 32; b++) begin
         if (!m[b] && (p[b] != a[b])) return 1'b0;
      end
      return 1'b1;
   endfunction

   // advances the expected state by one clock; returns the expected brk_req after the edge
   function automatic logic model_step(input logic we, input logic [4:0] ix, input logic [31:0] d,
                                       input logic v, input logic [31:0] p);
      logic fire = 1'b0;
      logic twr  = we && (ix == IX_TRIG);
      if (!twr && v && m_l1 && pc_hits(p, m_addr, m_mask)) begin
         if (!m_l2) fire = 1'b1;
         else if (m_armed) begin fire = 1'b1; m_armed = 1'b0; end
         else m_armed = 1'b1;
      end
      if (we) begin
         if (ix == IX_ADDR) m_addr = d;
         if (ix == IX_MASK) m_mask = d;
         if (twr) begin m_l1 = d[0]; m_l2 = d[16]; m_armed = 1'b0; end
      end
      return fire;
   endfunction

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: brk_req actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic tick(input logic we, input logic [4:0] ix, input logic [31:0] d,
                       input logic v, input logic [31:0] p, input string tag);
      logic exp;
      reg_wr_en = we; reg_wr_idx = ix; reg_wr_data = d; pc_valid = v; pc = p;
      exp = model_step(we, ix, d, v, p);
      @(posedge clk);
      @(negedge clk);
      check(tag, brk_req, exp);
   endtask

   task automatic run_pc(input logic [31:0] p, input string tag);
      tick(1'b0, 5'h00, 32'h0, 1'b1, p, tag);
   endtask

   task automatic wr(input logic [4:0] ix, input logic [31:0] d, input string tag);
      tick(1'b1, ix, d, 1'b0, 32'h0, tag);
   endtask

   task automatic report;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #(CLK_NS * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog R1..: actual=running expected=finished");
      report();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1", brk_req, 1'b0);

      // R1: nothing fires with cleared registers
      for (int i = 0; i < 4; i++) run_pc(32'(i), "R1");
      // R7: trigger write in a matching cycle neither arms nor fires
      tick(1'b1, IX_TRIG, 32'h0000_0001, 1'b1, 32'h0, "R7");
      run_pc(32'h0, "R4");
      run_pc(32'h1, "R1");

      // R2: write-cycle compare uses the old address, then masked matching
      tick(1'b1, IX_ADDR, 32'h1000_0040, 1'b1, 32'h1000_0040, "R2");
      wr(IX_MASK, 32'h0000_000F, "R2");
      run_pc(32'h1000_004C, "R2");
      run_pc(32'h1000_005C, "R2");
      run_pc(32'h1000_0040, "R4");
      run_pc(32'h1000_0041, "R4");

      // R6: invalid cycle with a matching PC
      tick(1'b0, 5'h00, 32'h0, 1'b0, 32'h1000_0040, "R6");

      // R8: writes to unused indices change nothing
      tick(1'b1, 5'h0A, 32'hFFFF_FFFF, 1'b1, 32'h1000_0043, "R8");
      wr(5'h06, 32'h0000_0000, "R8");
      run_pc(32'h1000_0043, "R8");
      run_pc(32'h0000_0000, "R8");

      // R5: two-level arming
      wr(IX_TRIG, 32'h0001_0001, "R5");
      run_pc(32'h1000_0040, "R5");
      tick(1'b0, 5'h00, 32'h0, 1'b0, 32'h1000_0040, "R6");
      run_pc(32'h2000_0000, "R5");
      run_pc(32'h1000_0040, "R5");
      run_pc(32'h1000_0040, "R5");
      run_pc(32'h1000_0040, "R5");

      // R7: trigger write drops the armed state
      run_pc(32'h1000_0040, "R7");
      wr(IX_TRIG, 32'h0001_0001, "R7");
      run_pc(32'h1000_0040, "R7");
      run_pc(32'h1000_0040, "R7");

      // R3: second level alone, other bits, and extra bits with level one
      wr(IX_TRIG, 32'h0001_0000, "R3");
      run_pc(32'h1000_0040, "R3");
      run_pc(32'h1000_0040, "R3");
      wr(IX_TRIG, 32'hFFFE_FFFE, "R3");
      run_pc(32'h1000_0040, "R3");
      wr(IX_TRIG, 32'h00F0_0F01, "R3");
      run_pc(32'h1000_0040, "R3");

      // constrained random traffic
      for (int n = 0; n < 4000; n++) begin
         int unsigned r = $urandom % 100;
         logic        we = 1'b0;
         logic [4:0]  ix = 5'h00;
         logic [31:0] d  = 32'h0;
         logic        v  = ($urandom % 4) != 0;
         logic [31:0] p;
         string       tag;
         if (r < 4) begin
            we = 1'b1; ix = IX_TRIG;
            case ($urandom % 5)
               0: d = 32'h0000_0001;
               1: d = 32'h0001_0001;
               2: d = 32'h0001_0000;
               3: d = 32'h0000_0000;
               default: d = $urandom;
            endcase
         end else if (r < 7) begin
            we = 1'b1; ix = IX_ADDR; d = $urandom;
         end else if (r < 10) begin
            we = 1'b1; ix = IX_MASK; d = $urandom & $urandom & $urandom;
         end else if (r < 12) begin
            we = 1'b1; ix = 5'($urandom % 7); d = $urandom;
         end
         if (($urandom % 10) < 7) p = m_addr ^ ($urandom & m_mask);
         else                     p = $urandom;
         if (we && ix == IX_TRIG)  tag = "R7";
         else if (!m_l1)           tag = "R3";
         else if (!v)              tag = "R6";
         else if (m_l2)            tag = "R5";
         else                      tag = "R4";
         tick(we, ix, d, v, p, tag);
      end

      report();
      $finish;
   end

endmodule